// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This block is a purely combinational shifter for a small accumulator-style datapath. It moves an operand by exactly one bit position. The operand is either one byte or a double-width word made of two bytes. The available operations are a left shift, an arithmetic right shift, a logical right shift, and left and right rotates through a carry bit. Alongside the result it produces the four condition flags that a branch unit consumes: negative, zero, overflow and carry.

An instruction decoder drives the operation code, the width select and the current carry flag. It takes the result and the flags back in the same cycle. In byte mode only the low byte is processed, and the upper byte of the operand is forwarded unchanged. Any operation the unit does not support at the selected width is rejected. A rejected request returns the operand untouched, keeps the incoming carry and raises an illegal indication.

Operation codes on `op_i`: 0 = left shift (arithmetic and logical are the same), 1 = arithmetic right shift, 2 = logical right shift, 3 = rotate left through carry, 4 = rotate right through carry. Codes 5 to 7 are unassigned.

Top module: `shift_rot_unit`

## Requirements
- R1: Left shift (code 0) moves a 0 into bit 0, and the previous top bit of the selected width becomes `c_o`.
- R2: Arithmetic right shift (code 1, byte width only) keeps the previous top bit in the top position, and the previous bit 0 becomes `c_o`.
- R3: Logical right shift (code 2) moves a 0 into the top bit of the selected width, and the previous bit 0 becomes `c_o`.
- R4: Rotate left (code 3, byte width only) moves `c_i` into bit 0, and the previous top bit becomes `c_o`.
- R5: Rotate right (code 4, byte width only) moves `c_i` into the top bit, and the previous bit 0 becomes `c_o`.
- R6: With `wide_i` = 1, codes 0 and 2 act on all 16 bits of the operand.
- R7: A request with `wide_i` = 1 and code 1, 3 or 4, or any request with code 5, 6 or 7, returns `res_o` equal to `opd_i` and `c_o` equal to `c_i`, and sets `illegal_o` to 1. Every other request clears `illegal_o`.
- R8: With `wide_i` = 0, `res_o[15:8]` equals `opd_i[15:8]` for every code.
- R9: `n_o` is the top bit of the result at the selected width (bit 7 or bit 15). `z_o` is 1 exactly when the result bits at the selected width are all zero, so in byte mode the upper byte is ignored.
- R10: `v_o` equals `n_o` xor `c_o` after every request, including rejected ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_i | input | 16 | Operand; the low byte is used in byte mode |
| wide_i | input | 1 | 0 = byte operand, 1 = 16-bit double operand |
| op_i | input | 3 | Operation code (see above) |
| c_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag (N xor C) |
| c_o | output | 1 | Outgoing carry flag |
| illegal_o | output | 1 | Request rejected at this width or code |

## Verification
The bench builds the unit with its default byte width of 8, which makes the double operand 16 bits. At this width all 256 byte operands can be swept under every operation code with both carry values, so every carry-in and carry-out path and both flag edges are covered exhaustively. The double width is covered with directed boundary words and a walking-bit pattern. These include words that become zero only at 16 bits and byte operands with a non-zero upper byte.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;

  localparam int SR_OP_W = 3;

  typedef enum logic [SR_OP_W-1:0] {
    SR_SHL = 3'd0,
    SR_ASR = 3'd1,
    SR_LSR = 3'd2,
    SR_ROL = 3'd3,
    SR_ROR = 3'd4
  } sr_op_e;

endpackage

// File: rtl/sr_lane.sv
module sr_lane
  import shift_rot_pkg::*;
#(
  parameter int W        = 8,
  parameter bit FULL_SET = 1'b1
) (
  input  logic [W-1:0]       opd_i,
  input  logic [SR_OP_W-1:0] op_i,
  input  logic               c_i,
  output logic [W-1:0]       res_o,
  output logic               c_o,
  output logic               bad_o
);

  logic [W-1:0] up_w;
  logic [W-1:0] dn_fill0;
  logic [W-1:0] dn_sign;
  logic [W-1:0] dn_carry;
  logic [W-1:0] up_carry;

  assign up_w     = {opd_i[W-2:0], 1'b0};
  assign up_carry = {opd_i[W-2:0], c_i};
  assign dn_fill0 = {1'b0, opd_i[W-1:1]};
  assign dn_sign  = {opd_i[W-1], opd_i[W-1:1]};
  assign dn_carry = {c_i, opd_i[W-1:1]};

  generate
    if (FULL_SET) begin : g_full
      always_comb begin
        res_o = opd_i;
        c_o   = c_i;
        bad_o = 1'b0;
        case (op_i)
          SR_SHL: begin res_o = up_w;     c_o = opd_i[W-1]; end
          SR_ASR: begin res_o = dn_sign;  c_o = opd_i[0];   end
          SR_LSR: begin res_o = dn_fill0; c_o = opd_i[0];   end
          SR_ROL: begin res_o = up_carry; c_o = opd_i[W-1]; end
          SR_ROR: begin res_o = dn_carry; c_o = opd_i[0];   end
          default: bad_o = 1'b1;
        endcase
      end
    end else begin : g_shift_only
      always_comb begin
        res_o = opd_i;
        c_o   = c_i;
        bad_o = 1'b0;
        case (op_i)
          SR_SHL: begin res_o = up_w;     c_o = opd_i[W-1]; end
          SR_LSR: begin res_o = dn_fill0; c_o = opd_i[0];   end
          default: bad_o = 1'b1;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/sr_flags.sv
module sr_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         c_i,
  output logic         n_o,
  output logic         z_o,
  output logic         v_o
);

  always_comb begin
    n_o = res_i[W-1];
    z_o = ~|res_i;
    v_o = n_o ^ c_i;
  end

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shift_rot_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] opd_i,
  input  logic                wide_i,
  input  logic [SR_OP_W-1:0]  op_i,
  input  logic                c_i,
  output logic [2*BYTE_W-1:0] res_o,
  output logic                n_o,
  output logic                z_o,
  output logic                v_o,
  output logic                c_o,
  output logic                illegal_o
);

  localparam int DBL_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] res_b;
  logic [DBL_W-1:0]  res_d;
  logic              c_b, c_d, bad_b, bad_d;
  logic              n_b, z_b, v_b, n_d, z_d, v_d;

  sr_lane #(.W(BYTE_W), .FULL_SET(1'b1)) u_lane_b (
    .opd_i (opd_i[BYTE_W-1:0]),
    .op_i  (op_i),
    .c_i   (c_i),
    .res_o (res_b),
    .c_o   (c_b),
    .bad_o (bad_b)
  );

  sr_lane #(.W(DBL_W), .FULL_SET(1'b0)) u_lane_d (
    .opd_i (opd_i),
    .op_i  (op_i),
    .c_i   (c_i),
    .res_o (res_d),
    .c_o   (c_d),
    .bad_o (bad_d)
  );

  sr_flags #(.W(BYTE_W)) u_flg_b (
    .res_i (res_b),
    .c_i   (c_b),
    .n_o   (n_b),
    .z_o   (z_b),
    .v_o   (v_b)
  );

  sr_flags #(.W(DBL_W)) u_flg_d (
    .res_i (res_d),
    .c_i   (c_d),
    .n_o   (n_d),
    .z_o   (z_d),
    .v_o   (v_d)
  );

  always_comb begin
    if (wide_i) begin
      res_o     = res_d;
      c_o       = c_d;
      n_o       = n_d;
      z_o       = z_d;
      v_o       = v_d;
      illegal_o = bad_d;
    end else begin
      res_o     = {opd_i[DBL_W-1:BYTE_W], res_b};
      c_o       = c_b;
      n_o       = n_b;
      z_o       = z_b;
      v_o       = v_b;
      illegal_o = bad_b;
    end
  end

  // Cross-lane checks on the assembled outputs
  always_comb begin
    if (illegal_o) begin
      assert_illegal_passthru_R7: assert (res_o == opd_i && c_o == c_i)
        else $error("rejected request altered operand or carry");
    end
    if (!wide_i) begin
      assert_upper_byte_kept_R8: assert (res_o[DBL_W-1:BYTE_W] == opd_i[DBL_W-1:BYTE_W])
        else $error("upper byte changed in byte mode");
    end
    if (!illegal_o && !wide_i && op_i == SR_ASR) begin
      assert_asr_sign_kept_R2: assert (res_o[BYTE_W-1] == opd_i[BYTE_W-1])
        else $error("arithmetic right shift lost sign");
    end
    if (!illegal_o && op_i == SR_ROL) begin
      assert_rol_carry_enters_R4: assert (res_o[0] == c_i)
        else $error("rotate left did not take carry in");
    end
    if (!illegal_o && op_i == SR_LSR) begin
      assert_lsr_zero_fill_R3: assert (wide_i ? !res_o[DBL_W-1] : !res_o[BYTE_W-1])
        else $error("logical right shift did not fill zero");
    end
  end

endmodule

// File: tb/shift_rot_unit_tb.sv
`timescale 1ns/1ps
module shift_rot_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opd;
  logic        wide;
  logic [2:0]  op;
  logic        cin;
  logic [15:0] res;
  logic        n, z, v, c, ill;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [15:0] res;
    logic        n, z, v, c, ill;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  shift_rot_unit u_dut (
    .opd_i(opd), .wide_i(wide), .op_i(op), .c_i(cin),
    .res_o(res), .n_o(n), .z_o(z), .v_o(v), .c_o(c), .illegal_o(ill)
  );

  function automatic exp_t model(logic [15:0] a, logic w, logic [2:0] o, logic ci);
    exp_t        e;
    int          wd   = w ? 16 : 8;
    logic [15:0] mask = w ? 16'hFFFF : 16'h00FF;
    logic [15:0] lo   = a & mask;
    logic        hi   = lo[wd-1];
    logic [15:0] r;
    logic        cc;
    e.ill = (o > 3'd4) || (w && (o == 3'd1 || o == 3'd3 || o == 3'd4));
    r  = lo;
    cc = ci;
    if (!e.ill) begin
      case (o)
        3'd0: begin r = (lo << 1) & mask; cc = hi; end
        3'd1: begin r = (lo >> 1) | (hi ? (16'h1 << (wd-1)) : 16'h0); cc = lo[0]; end
        3'd2: begin r = lo >> 1; cc = lo[0]; end
        3'd3: begin r = ((lo << 1) | {15'd0, ci}) & mask; cc = hi; end
        default: begin r = (lo >> 1) | (ci ? (16'h1 << (wd-1)) : 16'h0); cc = lo[0]; end
      endcase
    end
    e.res = w ? r : {a[15:8], r[7:0]};
    e.n   = r[wd-1];
    e.z   = ((r & mask) == 16'h0);
    e.c   = cc;
    e.v   = e.n ^ cc;
    return e;
  endfunction

  task automatic drive(logic [15:0] a, logic w, logic [2:0] o, logic ci, string tag);
    @(negedge clk);
    opd  = a;
    wide = w;
    op   = o;
    cin  = ci;
    exp_q.push_back(model(a, w, o, ci));
    tag_q.push_back(tag);
  endtask

  // Monitor: inputs change on the falling edge, results are compared on the rising edge
  always @(posedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      exp_t  e;
      exp_t  g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = {res, n, z, v, c, ill};
      checks++;
      if (g !== e) begin
        errors++;
        $display("FAIL %s: got res=%h n=%b z=%b v=%b c=%b ill=%b exp res=%h n=%b z=%b v=%b c=%b ill=%b",
                 t, g.res, g.n, g.z, g.v, g.c, g.ill, e.res, e.n, e.z, e.v, e.c, e.ill);
      end
    end
  end

  initial begin
    opd = 16'h0; wide = 1'b0; op = 3'd0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: zero operand, left shift, zero carry
    drive(16'h0000, 1'b0, 3'd0, 1'b0, "R9 idle zero");
    // Directed byte cases
    drive(16'h0040, 1'b0, 3'd0, 1'b0, "R1 R10 shl into sign");
    drive(16'h0080, 1'b0, 3'd0, 1'b1, "R1 R9 shl to zero");
    drive(16'h0081, 1'b0, 3'd1, 1'b0, "R2 asr negative");
    drive(16'h0001, 1'b0, 3'd2, 1'b0, "R3 R9 lsr to zero");
    drive(16'h00FF, 1'b0, 3'd2, 1'b1, "R3 lsr all ones");
    drive(16'h0000, 1'b0, 3'd3, 1'b1, "R4 rol carry in");
    drive(16'h0080, 1'b0, 3'd3, 1'b0, "R4 R9 rol carry out");
    drive(16'h0000, 1'b0, 3'd4, 1'b1, "R5 ror carry in");
    drive(16'h0001, 1'b0, 3'd4, 1'b0, "R5 R10 ror carry out");
    drive(16'hAB01, 1'b0, 3'd2, 1'b0, "R8 R9 upper byte ignored for zero");
    drive(16'h5A80, 1'b0, 3'd3, 1'b1, "R8 rol keeps upper byte");
    // Double width
    drive(16'h4000, 1'b1, 3'd0, 1'b0, "R6 R10 dbl shl into sign");
    drive(16'h8000, 1'b1, 3'd0, 1'b0, "R6 R9 dbl shl to zero");
    drive(16'h0100, 1'b1, 3'd2, 1'b1, "R6 dbl lsr across bytes");
    drive(16'h0001, 1'b1, 3'd2, 1'b0, "R6 R9 dbl lsr to zero");
    drive(16'h8001, 1'b1, 3'd1, 1'b1, "R7 dbl asr rejected");
    drive(16'h8001, 1'b1, 3'd3, 1'b0, "R7 dbl rol rejected");
    drive(16'h0000, 1'b1, 3'd4, 1'b1, "R7 dbl ror rejected");
    drive(16'h12F0, 1'b0, 3'd5, 1'b1, "R7 code5 byte rejected");
    drive(16'hFFFF, 1'b1, 3'd7, 1'b0, "R7 code7 dbl rejected");
    // Exhaustive byte sweep
    for (int a = 0; a < 256; a++) begin
      for (int o = 0; o < 8; o++) begin
        for (int ci = 0; ci < 2; ci++) begin
          drive({8'(a ^ 8'h3C), 8'(a)}, 1'b0, 3'(o), 1'(ci), "R1 R2 R3 R4 R5 R8 R9 R10 byte sweep");
        end
      end
    end
    // Walking bits on the double operand
    for (int b = 0; b < 16; b++) begin
      for (int o = 0; o < 8; o++) begin
        drive(16'h1 << b, 1'b1, 3'(o), 1'(b & 1), "R6 R7 R9 R10 dbl walk");
        drive(~(16'h1 << b), 1'b1, 3'(o), 1'(~b & 1), "R6 R7 R9 R10 dbl walk inv");
      end
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule